// File: doc/BRIEF.md
# Colour LCD Controller Register and Interrupt Unit

This block is the software-visible register bank of a simple colour LCD controller. It sits on a peripheral bus with a word-granular address that covers a 4 KB window. It holds four panel timing words, the frame-buffer base addresses for the upper and lower panel halves, a control word and an interrupt mask. From the timing words it decodes the active panel size. From the control word it decodes an enable flag and a pixel-depth code.

An internal frame tick stands in for the vertical refresh. While the controller is enabled, the tick periodically sets two interrupt causes together. Software reads these causes raw or masked and clears them by writing ones. A level interrupt output follows the masked causes.

A 128-word palette window stores words for read-back and forwards every palette write as a strobe with its index and data. The palette window is the only part of the map that the colour-expansion logic outside this block sees. The top of the map returns eight identification bytes that depend on a variant parameter. The same parameter also swaps the positions of the control and mask words. Any offset without a register reads zero, ignores writes and pulses an error flag.

Top module: `lcd_regbank`

## Requirements
- R1: After reset every register reads zero. Timing words at byte offsets 0x00, 0x04, 0x08 and 0x0C, and the panel bases at 0x10 (upper) and 0x14 (lower), read back all 32 written bits. The bases also drive the `upperBase` and `lowerBase` outputs.
- R2: `panelWidth` equals (timing0 bits [7:2] + 1) * 16 pixels. No other bit of timing0 affects it.
- R3: `panelHeight` equals timing0-independent timing1 bits [9:0] + 1 lines.
- R4: With VARIANT 0 the control word is at 0x18 and the mask at 0x1C. With VARIANT 1 the two are swapped. The control word keeps bits [15:0] and the mask keeps bits [3:0]; all other bits read zero.
- R5: `panelEnable` is high only when control bit 0 and control bit 11 are both set. `pixDepth` equals control bits [3:1].
- R6: Offset 0x20 reads the raw status in bits [3:0]. Offset 0x24 reads raw status AND mask.
- R7: A write to 0x28 clears each status bit written as 1 and leaves the others unchanged. When a frame tick falls in the same cycle, the tick's bits end up set.
- R8: `irq` is high exactly when raw status AND mask is non-zero.
- R9: While enabled, the frame tick sets status bits 2 and 3 together every TICK_CYCLES cycles. The first tick lands TICK_CYCLES clock edges after the edge that enabled the controller. While disabled, no tick occurs and the period count restarts.
- R10: Byte offsets 0xFE0 to 0xFFC read one identification byte per word. For VARIANT 0 the bytes are 10,11,04,00,0D,F0,05,B1 (hex). VARIANT 1 reads 11 in the first word and 24 in the third word.
- R11: Offsets 0x200 to 0x3FC form 128 palette words that read back what was written. During a write cycle, `palWrEn` is high with `palIdx` set to (offset-0x200)/4 and `palWdata` set to the write data.
- R12: An access to an offset with no register reads zero, changes no register, and raises `busErr` for exactly the one cycle after the access edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 10 | Word address (byte offset / 4) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational in the access cycle |
| busErr | output | 1 | One-cycle pulse after an access to an undefined offset |
| irq | output | 1 | Level interrupt |
| panelWidth | output | 11 | Decoded panel width in pixels |
| panelHeight | output | 11 | Decoded panel height in lines |
| panelEnable | output | 1 | Controller enabled and powered |
| pixDepth | output | 3 | Pixel-depth code |
| upperBase | output | 32 | Upper panel frame base |
| lowerBase | output | 32 | Lower panel frame base |
| palWrEn | output | 1 | Palette write strobe |
| palIdx | output | 7 | Palette word index |
| palWdata | output | 32 | Palette write data |

## Verification
The bench builds two instances on one shared bus: one with VARIANT 0 and one with VARIANT 1, both with TICK_CYCLES set to 16. The short period lets every tick-dependent case run in a few dozen cycles. These cases include the exact landing edge of the first tick, a clear that collides with a tick, and the refill of status before each step of the sweeps. With this setup the bench sweeps all 64 width codes, all 1024 height codes, all 128 palette words, all eight identification bytes of both variants, and every 4-bit clear and mask pattern against a tick-filled status.

// File: rtl/lcd_regbank_pkg.sv
package lcd_regbank_pkg;

  localparam int DATA_W    = 32;
  localparam int WADDR_W   = 10;
  localparam int TIM_N     = 4;
  localparam int TIM_IDX_W = $clog2(TIM_N);
  localparam int STAT_W    = 4;
  localparam int CTRL_W    = 16;
  localparam int DIM_W     = 11;
  localparam int PAL_WORDS = 128;
  localparam int PAL_IDX_W = $clog2(PAL_WORDS);

  localparam int NB_BIT    = 2;
  localparam int VC_BIT    = 3;
  localparam int EN_BIT    = 0;
  localparam int PWR_BIT   = 11;
  localparam int DEPTH_LSB = 1;
  localparam int DEPTH_W   = 3;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_TIM,
    RD_UPB,
    RD_LOB,
    RD_CTRL,
    RD_MASK,
    RD_RAW,
    RD_MSKD,
    RD_PAL,
    RD_ID
  } rdSel_e;

  typedef struct packed {
    logic [TIM_N-1:0]     wrTim;
    logic [TIM_IDX_W-1:0] timIdx;
    logic                 wrUpBase;
    logic                 wrLoBase;
    logic                 wrCtrl;
    logic                 wrMask;
    logic                 wrClear;
    logic                 wrPal;
    rdSel_e               rdSel;
    logic                 undef;
  } regStrobe_t;

  function automatic logic [7:0] idByte(input int variant, input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = (variant == 0) ? 8'h10 : 8'h11;
      3'd1:    b = 8'h11;
      3'd2:    b = (variant == 0) ? 8'h04 : 8'h24;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/lcd_frame_tick.sv
module lcd_frame_tick #(
  parameter int TICK_CYCLES = 800000
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic tick
);

  generate
    if (TICK_CYCLES <= 1) begin : g_every
      logic unusedClk;
      assign unusedClk = clk ^ rstN;
      assign tick = run;
    end else begin : g_count
      localparam int CNT_W = $clog2(TICK_CYCLES);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            cnt <= '0;
        else if (!run)        cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end

      assign tick = run && (cnt == LAST);
    end
  endgenerate

endmodule

// File: rtl/lcd_regbank_ctrl.sv
module lcd_regbank_ctrl
  import lcd_regbank_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [WADDR_W-1:0] busAddr,
  output regStrobe_t         strb,
  output logic               busErr
);

  localparam logic [3:0] CTRL_WORD = (VARIANT == 0) ? 4'd6 : 4'd7;
  localparam logic [3:0] MASK_WORD = (VARIANT == 0) ? 4'd7 : 4'd6;

  logic wrAcc;
  assign wrAcc = busSel & busWr;

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    if (busAddr[9:7] == 3'b001) begin
      strb.rdSel = RD_PAL;
      strb.wrPal = wrAcc;
    end else if (busAddr[9:3] == 7'h7F) begin
      strb.rdSel = RD_ID;
    end else if (busAddr[9:4] == 6'd0) begin
      if (busAddr[3:2] == 2'b00) begin
        strb.rdSel               = RD_TIM;
        strb.timIdx              = busAddr[1:0];
        strb.wrTim[busAddr[1:0]] = wrAcc;
      end else if (busAddr[3:0] == 4'd4) begin
        strb.rdSel    = RD_UPB;
        strb.wrUpBase = wrAcc;
      end else if (busAddr[3:0] == 4'd5) begin
        strb.rdSel    = RD_LOB;
        strb.wrLoBase = wrAcc;
      end else if (busAddr[3:0] == CTRL_WORD) begin
        strb.rdSel  = RD_CTRL;
        strb.wrCtrl = wrAcc;
      end else if (busAddr[3:0] == MASK_WORD) begin
        strb.rdSel  = RD_MASK;
        strb.wrMask = wrAcc;
      end else if (busAddr[3:0] == 4'd8) begin
        strb.rdSel = RD_RAW;
      end else if (busAddr[3:0] == 4'd9) begin
        strb.rdSel = RD_MSKD;
      end else if (busAddr[3:0] == 4'd10) begin
        strb.wrClear = wrAcc;
      end else begin
        strb.undef = 1'b1;
      end
    end else begin
      strb.undef = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busErr <= 1'b0;
    else       busErr <= busSel & strb.undef;
  end

endmodule

// File: rtl/lcd_regbank_datapath.sv
module lcd_regbank_datapath
  import lcd_regbank_pkg::*;
#(
  parameter int VARIANT     = 0,
  parameter int TICK_CYCLES = 800000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strb,
  input  logic [PAL_IDX_W-1:0] wordIdx,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic [STAT_W-1:0]    rawStat,
  output logic                 irq,
  output logic [DIM_W-1:0]     panelWidth,
  output logic [DIM_W-1:0]     panelHeight,
  output logic                 panelEnable,
  output logic [DEPTH_W-1:0]   pixDepth,
  output logic [DATA_W-1:0]    upperBase,
  output logic [DATA_W-1:0]    lowerBase,
  output logic                 palWrEn,
  output logic [PAL_IDX_W-1:0] palIdx,
  output logic [DATA_W-1:0]    palWdata
);

  localparam logic [STAT_W-1:0] TICK_BITS = STAT_W'((1 << NB_BIT) | (1 << VC_BIT));

  logic [TIM_N-1:0][DATA_W-1:0] timReg;
  logic [DATA_W-1:0]            upReg, loReg;
  logic [CTRL_W-1:0]            ctrlReg;
  logic [STAT_W-1:0]            maskReg, statReg, clrBits, setBits;
  logic [DATA_W-1:0]            palMem [PAL_WORDS];
  logic                         frameTick;

  lcd_frame_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk  (clk),
    .rstN (rstN),
    .run  (panelEnable),
    .tick (frameTick)
  );

  assign clrBits = strb.wrClear ? busWdata[STAT_W-1:0] : '0;
  assign setBits = frameTick ? TICK_BITS : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timReg  <= '0;
      upReg   <= '0;
      loReg   <= '0;
      ctrlReg <= '0;
      maskReg <= '0;
      statReg <= '0;
    end else begin
      for (int i = 0; i < TIM_N; i++) begin
        if (strb.wrTim[i]) timReg[i] <= busWdata;
      end
      if (strb.wrUpBase) upReg   <= busWdata;
      if (strb.wrLoBase) loReg   <= busWdata;
      if (strb.wrCtrl)   ctrlReg <= busWdata[CTRL_W-1:0];
      if (strb.wrMask)   maskReg <= busWdata[STAT_W-1:0];
      statReg <= (statReg & ~clrBits) | setBits;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrPal) palMem[wordIdx] <= busWdata;
  end

  always_comb begin
    case (strb.rdSel)
      RD_TIM:  busRdata = timReg[strb.timIdx];
      RD_UPB:  busRdata = upReg;
      RD_LOB:  busRdata = loReg;
      RD_CTRL: busRdata = DATA_W'(ctrlReg);
      RD_MASK: busRdata = DATA_W'(maskReg);
      RD_RAW:  busRdata = DATA_W'(statReg);
      RD_MSKD: busRdata = DATA_W'(statReg & maskReg);
      RD_PAL:  busRdata = palMem[wordIdx];
      RD_ID:   busRdata = DATA_W'(idByte(VARIANT, wordIdx[2:0]));
      default: busRdata = '0;
    endcase
  end

  assign panelWidth  = (DIM_W'(timReg[0][7:2]) + DIM_W'(1)) << 4;
  assign panelHeight = DIM_W'(timReg[1][9:0]) + DIM_W'(1);
  assign panelEnable = ctrlReg[EN_BIT] & ctrlReg[PWR_BIT];
  assign pixDepth    = ctrlReg[DEPTH_LSB +: DEPTH_W];
  assign upperBase   = upReg;
  assign lowerBase   = loReg;
  assign rawStat     = statReg;
  assign irq         = |(statReg & maskReg);
  assign palWrEn     = strb.wrPal;
  assign palIdx      = wordIdx;
  assign palWdata    = busWdata;

endmodule

// File: rtl/lcd_regbank.sv
module lcd_regbank
  import lcd_regbank_pkg::*;
#(
  parameter int VARIANT     = 0,
  parameter int TICK_CYCLES = 800000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [WADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 busErr,
  output logic                 irq,
  output logic [DIM_W-1:0]     panelWidth,
  output logic [DIM_W-1:0]     panelHeight,
  output logic                 panelEnable,
  output logic [DEPTH_W-1:0]   pixDepth,
  output logic [DATA_W-1:0]    upperBase,
  output logic [DATA_W-1:0]    lowerBase,
  output logic                 palWrEn,
  output logic [PAL_IDX_W-1:0] palIdx,
  output logic [DATA_W-1:0]    palWdata
);

  regStrobe_t        strb;
  logic [STAT_W-1:0] rawStat;

  lcd_regbank_ctrl #(.VARIANT(VARIANT)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strb    (strb),
    .busErr  (busErr)
  );

  lcd_regbank_datapath #(.VARIANT(VARIANT), .TICK_CYCLES(TICK_CYCLES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wordIdx     (busAddr[PAL_IDX_W-1:0]),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .rawStat     (rawStat),
    .irq         (irq),
    .panelWidth  (panelWidth),
    .panelHeight (panelHeight),
    .panelEnable (panelEnable),
    .pixDepth    (pixDepth),
    .upperBase   (upperBase),
    .lowerBase   (lowerBase),
    .palWrEn     (palWrEn),
    .palIdx      (palIdx),
    .palWdata    (palWdata)
  );

endmodule

// File: rtl/lcd_regbank_checker.sv
module lcd_regbank_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWr,
  input logic [9:0]  busAddr,
  input logic [31:0] busWdata,
  input logic        busErr,
  input logic        irq,
  input logic [10:0] panelWidth,
  input logic [10:0] panelHeight,
  input logic        panelEnable,
  input logic [31:0] upperBase,
  input logic [3:0]  rawStat
);

  assert_width_grid_R2: assert property (@(posedge clk) disable iff (!rstN)
    (panelWidth[3:0] == 4'd0) && (panelWidth != 11'd0) && (panelWidth <= 11'd1024));

  assert_height_nonzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (panelHeight != 11'd0) && (panelHeight <= 11'd1024));

  assert_full_clear_drops_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == 10'd10 && busWdata[3:0] == 4'hF && !panelEnable) |=> !irq);

  assert_tick_sets_pair_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawStat[2]) |-> rawStat[3]);

  assert_tick_needs_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawStat[3]) |-> $past(panelEnable));

  assert_err_follows_access_R12: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busSel));

  assert_undef_write_inert_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == 10'd12) |=> $stable(upperBase));

endmodule

bind lcd_regbank lcd_regbank_checker u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .busSel      (busSel),
  .busWr       (busWr),
  .busAddr     (busAddr),
  .busWdata    (busWdata),
  .busErr      (busErr),
  .irq         (irq),
  .panelWidth  (panelWidth),
  .panelHeight (panelHeight),
  .panelEnable (panelEnable),
  .upperBase   (upperBase),
  .rawStat     (rawStat)
);

// File: tb/lcd_regbank_bench.sv
module lcd_regbank_bench;

  localparam int TICK = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWdata = '0;

  logic [31:0] rdA, rdB, upA, loA, palWdataA, upB, loB, palWdataB;
  logic        errA, errB, irqA, irqB, enA, enB, palWrEnA, palWrEnB;
  logic [10:0] widthA, heightA, widthB, heightB;
  logic [2:0]  depthA, depthB;
  logic [6:0]  palIdxA, palIdxB;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lcd_regbank #(.VARIANT(0), .TICK_CYCLES(TICK)) u_lcd_regbank (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rdA), .busErr(errA), .irq(irqA),
    .panelWidth(widthA), .panelHeight(heightA), .panelEnable(enA), .pixDepth(depthA),
    .upperBase(upA), .lowerBase(loA), .palWrEn(palWrEnA), .palIdx(palIdxA),
    .palWdata(palWdataA)
  );

  lcd_regbank #(.VARIANT(1), .TICK_CYCLES(TICK)) u_lcd_regbank_alt (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rdB), .busErr(errB), .irq(irqB),
    .panelWidth(widthB), .panelHeight(heightB), .panelEnable(enB), .pixDepth(depthB),
    .upperBase(upB), .lowerBase(loB), .palWrEn(palWrEnB), .palIdx(palIdxB),
    .palWdata(palWdataB)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // called at a negedge; one clock edge passes
  task automatic wr(input logic [11:0] off, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = off[11:2]; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  // called at a negedge; no clock edge passes
  task automatic rd(input logic [11:0] off, output logic [31:0] a, output logic [31:0] b);
    busSel = 1'b1; busWr = 1'b0; busAddr = off[11:2];
    #1;
    a = rdA; b = rdB;
    busSel = 1'b0;
  endtask

  task automatic fillStatus();
    wr(12'h018, 32'h0000_0801);
    repeat (TICK) @(negedge clk);
    wr(12'h018, 32'h0);
  endtask

  function automatic logic [7:0] expId(input int variant, input int i);
    logic [7:0] t [8];
    t = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (variant == 1 && i == 0) return 8'h11;
    if (variant == 1 && i == 2) return 8'h24;
    return t[i];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h000, a, b); check("R1 reset timing0", a, 0);
    rd(12'h010, a, b); check("R1 reset upper base", a, 0);
    rd(12'h018, a, b); check("R1 reset control", a, 0);
    rd(12'h020, a, b); check("R1 reset status", a, 0);
    check("R8 reset irq", 32'(irqA), 0);
    check("R2 reset width", 32'(widthA), 16);
    check("R3 reset height", 32'(heightA), 1);
    check("R5 reset enable", 32'(enA), 0);

    // R1 read-back of timing and base words
    for (int i = 0; i < 4; i++) wr(12'(4 * i), 32'h1357_9BDF ^ (32'(i) * 32'h1111_1111));
    for (int i = 0; i < 4; i++) begin
      rd(12'(4 * i), a, b);
      check("R1 timing readback", a, 32'h1357_9BDF ^ (32'(i) * 32'h1111_1111));
    end
    wr(12'h010, 32'hCAFE_F00D);
    wr(12'h014, 32'h8765_4321);
    rd(12'h010, a, b); check("R1 upper readback", a, 32'hCAFE_F00D);
    rd(12'h014, a, b); check("R1 lower readback", a, 32'h8765_4321);
    check("R1 upperBase port", upA, 32'hCAFE_F00D);
    check("R1 lowerBase port", loA, 32'h8765_4321);

    // R2 all width codes
    for (int v = 0; v < 64; v++) begin
      wr(12'h000, 32'hBEEF_5A01 | (32'(v) << 2));
      check("R2 width", 32'(widthA), 32'((v + 1) * 16));
    end
    // R3 all height codes
    for (int h = 0; h < 1024; h++) begin
      wr(12'h004, 32'h5A5A_FC00 | 32'(h));
      check("R3 height", 32'(heightA), 32'(h + 1));
    end

    // R4 variant placement of control and mask
    wr(12'h018, 32'hFFFF_0805);
    rd(12'h018, a, b);
    check("R4 base control at 0x18", a, 32'h0000_0805);
    check("R4 alt mask at 0x18", b, 32'h5);
    check("R4 base enabled", 32'(enA), 1);
    check("R4 alt not enabled", 32'(enB), 0);
    check("R5 depth field", 32'(depthA), 2);
    wr(12'h018, 32'h0);
    wr(12'h01C, 32'hFFFF_FFFF);
    rd(12'h01C, a, b);
    check("R4 base mask at 0x1C", a, 32'hF);
    check("R4 alt control at 0x1C", b, 32'hFFFF);
    check("R4 alt enabled", 32'(enB), 1);
    check("R4 base stays off", 32'(enA), 0);
    wr(12'h01C, 32'h0);
    wr(12'h028, 32'hF);

    // R5 enable needs both bits; depth sweep
    for (int c = 0; c < 4; c++) begin
      wr(12'h018, 32'(c & 1) | (32'((c >> 1) & 1) << 11));
      check("R5 enable combo", 32'(enA), 32'(c == 3));
    end
    for (int dp = 0; dp < 8; dp++) begin
      wr(12'h018, 32'(dp) << 1);
      check("R5 depth", 32'(depthA), 32'(dp));
    end
    wr(12'h018, 32'h0);
    wr(12'h028, 32'hF);

    // R9 first tick lands TICK edges after enabling
    wr(12'h018, 32'h0000_0801);
    repeat (TICK - 1) @(negedge clk);
    rd(12'h020, a, b); check("R9 no tick before period", a, 0);
    @(negedge clk);
    rd(12'h020, a, b); check("R9 tick sets bits 2 and 3", a, 32'hC);
    wr(12'h018, 32'h0);
    wr(12'h028, 32'hF);
    repeat (3 * TICK) @(negedge clk);
    rd(12'h020, a, b); check("R9 no tick while disabled", a, 0);

    // R7 clear colliding with a tick
    wr(12'h018, 32'h0000_0801);
    repeat (TICK - 1) @(negedge clk);
    wr(12'h028, 32'hC);
    rd(12'h020, a, b); check("R7 tick wins over clear", a, 32'hC);
    wr(12'h018, 32'h0);
    wr(12'h028, 32'hF);

    // R7 clear pattern sweep
    for (int w = 0; w < 16; w++) begin
      fillStatus();
      wr(12'h028, 32'(w));
      rd(12'h020, a, b); check("R7 partial clear", a, 32'hC & ~32'(w) & 32'hF);
    end
    wr(12'h028, 32'hF);

    // R6 and R8 mask sweep
    for (int m = 0; m < 16; m++) begin
      fillStatus();
      wr(12'h01C, 32'(m));
      rd(12'h020, a, b); check("R6 raw status", a, 32'hC);
      rd(12'h024, a, b); check("R6 masked status", a, 32'hC & 32'(m));
      check("R8 irq level", 32'(irqA), 32'((m & 12) != 0));
      wr(12'h01C, 32'h0);
      wr(12'h028, 32'hF);
    end
    check("R8 irq low after clear", 32'(irqA), 0);

    // R10 identification bytes
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(4 * i), a, b);
      check("R10 base id", a, 32'(expId(0, i)));
      check("R10 alt id", b, 32'(expId(1, i)));
    end

    // R11 palette strobes and read-back
    for (int i = 0; i < 128; i++) begin
      busSel = 1'b1; busWr = 1'b1; busAddr = 10'h080 + 10'(i);
      busWdata = 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0101);
      #1;
      check("R11 palWrEn", 32'(palWrEnA), 1);
      check("R11 palIdx", 32'(palIdxA), 32'(i));
      check("R11 palWdata", palWdataA, 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0101));
      @(negedge clk);
      busSel = 1'b0; busWr = 1'b0;
    end
    #1;
    check("R11 palWrEn idle", 32'(palWrEnA), 0);
    @(negedge clk);
    for (int i = 0; i < 128; i++) begin
      rd(12'h200 + 12'(4 * i), a, b);
      check("R11 palette readback", a, 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0101));
    end

    // R12 undefined offsets
    wr(12'h030, 32'hFFFF_FFFF);
    check("R12 err after undefined write", 32'(errA), 1);
    wr(12'h400, 32'hFFFF_FFFF);
    check("R12 err after second undefined write", 32'(errA), 1);
    @(negedge clk);
    check("R12 err pulse ends", 32'(errA), 0);
    rd(12'h010, a, b); check("R12 upper base untouched", a, 32'hCAFE_F00D);
    rd(12'h014, a, b); check("R12 lower base untouched", a, 32'h8765_4321);
    rd(12'h018, a, b); check("R12 control untouched", a, 0);
    rd(12'h020, a, b); check("R12 status untouched", a, 0);
    busSel = 1'b1; busWr = 1'b0; busAddr = 10'h200;
    #1;
    check("R12 undefined reads zero", rdA, 0);
    @(negedge clk);
    busSel = 1'b0;
    check("R12 err after undefined read", 32'(errA), 1);
    wr(12'h010, 32'hCAFE_F00D);
    check("R12 no err on defined access", 32'(errA), 0);

    finishRun();
  end

endmodule